// File: doc/BRIEF.md
# Power-Management I2C Single-Write Engine

This block is a small, write-only I2C master that delivers one register write to a power-management device. Software stores a packed command word that names the target, the register and the data byte, and sets its start flag. The engine then runs a full bus transaction and drops the start flag when the bus is released, so software can poll that one bit to learn that the write has finished.

A separate clock word gives the SCL high and low periods in system-clock cycles. The hardware adds a fixed overhead to each period, so software programs the wanted period less that overhead. Only standard and fast rates are in use. A NACK from the device ends the transaction early and raises a sticky error flag, which software clears by writing 1 to it. Both bus lines are open-drain and are modelled as pull-low enables.

Top module: `i2c_bypass_writer`

## Requirements
- R1: In the command word the target address is bits 6:0, the register byte is bits 15:8, the data byte is bits 23:16 and the start flag is bit 24. `cmd_rdata` returns the stored fields at the same positions, with the start flag in bit 24 and zeros in every other bit.
- R2: A command write with bit 24 set, made while idle, runs exactly one transaction, and bit 24 of `cmd_rdata` reads 1 until the STOP. A command write with bit 24 clear stores the fields and starts nothing.
- R3: In the clock word the SCL high count is bits 7:0 and the low count is bits 15:8. Bits 31:16 have no effect on the bus timing.
- R4: Every SCL low phase inside a transaction lasts the low count plus 7 cycles. Every SCL high phase lasts the high count plus 5 cycles.
- R5: Counts of zero still give phases of 7 cycles (low) and 5 cycles (high).
- R6: The bus carries START, then the address followed by a 0 direction bit, then the register byte, then the data byte, each followed by an ACK slot, then STOP. Bits go MSB first, and SDA changes while SCL is high only for START and STOP.
- R7: A NACK in any ACK slot stops the transfer at that byte: STOP follows, bit 24 clears and `err_flag` is set. If every slot is ACKed, `err_flag` is unchanged.
- R8: `err_flag` stays set until a write with `err_clr_bit` = 1. A write with `err_clr_bit` = 0 leaves it set.
- R9: A command write made during a transaction is ignored. The stored fields do not change, and no further transaction follows.
- R10: After reset and while idle, both lines are released (`scl_drive_low` = 0, `sda_drive_low` = 0), `cmd_rdata` is 0 and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Stored command word, with the live start flag |
| cfg_we | input | 1 | Write strobe for the clock word |
| cfg_wdata | input | 32 | Clock word to write |
| err_clr_we | input | 1 | Write strobe for the error flag |
| err_clr_bit | input | 1 | 1 clears the error flag |
| err_flag | output | 1 | Sticky NACK flag |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
A slip in the sequencer's bit or byte counters shows up within one transaction. The receiving side then sees a wrong byte, a missing or extra ACK slot, or a STOP in the wrong place, all at the STOP of that same write. A wrong phase-timer load shows up on the next SCL edge as a wrong high or low run length. If the start flag and the sequencer state disagree, software either polls forever or sees completion before the STOP, so the poll result is compared with the STOP seen on the bus. A lost NACK shows as a clear `err_flag` within the few phases that follow the bad slot.

// File: rtl/i2cbw_pkg.sv
package i2cbw_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 7;
  localparam int BYTE_W     = 8;
  localparam int NBYTES     = 3;
  localparam int FRAME_W    = NBYTES * BYTE_W;
  localparam int ADDR_LSB   = 0;
  localparam int REG_LSB    = 8;
  localparam int DATA_LSB   = 16;
  localparam int VALID_BIT  = 24;
  localparam int CFG_HI_LSB = 0;
  localparam int CFG_LO_LSB = 8;
  localparam int HI_OFS     = 5;
  localparam int LO_OFS     = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT_LO, S_BIT_HI, S_STOP_LO, S_STOP_HI
  } seq_st_t;

  // Cycles in one SCL phase for a programmed count.
  function automatic int unsigned phase_cycles(int unsigned cnt, int unsigned ofs);
    return cnt + ofs;
  endfunction

  // Serial frame: address, write direction bit (0), register, data.
  function automatic logic [FRAME_W-1:0] build_frame(logic [ADDR_W-1:0] a,
                                                     logic [BYTE_W-1:0] r,
                                                     logic [BYTE_W-1:0] d);
    return {a, 1'b0, r, d};
  endfunction
endpackage

// File: rtl/i2cbw_phase_timer.sv
module i2cbw_phase_timer #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/i2cbw_regs.sv
module i2cbw_regs
  import i2cbw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [WORD_W-1:0]  cmd_wdata,
  input  logic               cfg_we,
  input  logic [WORD_W-1:0]  cfg_wdata,
  input  logic               err_clr_we,
  input  logic               err_clr_bit,
  input  logic               busy,
  input  logic               xfer_done,
  input  logic               nack_seen,
  output logic               launch,
  output logic [FRAME_W-1:0] launch_frame,
  output logic [CNT_W-1:0]   hi_cnt,
  output logic [CNT_W-1:0]   lo_cnt,
  output logic [WORD_W-1:0]  cmd_rdata,
  output logic               err_flag
);
  localparam int PAD_W = WORD_W - VALID_BIT - 1;

  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] reg_q, data_q;
  logic              valid_q, err_q;
  logic              accept;

  logic unused_wbits;
  assign unused_wbits = ^{cmd_wdata[WORD_W-1:VALID_BIT+1], cmd_wdata[ADDR_LSB+ADDR_W],
                          cfg_wdata[WORD_W-1:CFG_LO_LSB+CNT_W]};

  assign accept = cmd_we && !busy;
  assign launch = accept && cmd_wdata[VALID_BIT];
  assign launch_frame = build_frame(cmd_wdata[ADDR_LSB +: ADDR_W],
                                    cmd_wdata[REG_LSB +: BYTE_W],
                                    cmd_wdata[DATA_LSB +: BYTE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= cmd_wdata[ADDR_LSB +: ADDR_W];
        reg_q  <= cmd_wdata[REG_LSB +: BYTE_W];
        data_q <= cmd_wdata[DATA_LSB +: BYTE_W];
      end
      if (launch)         valid_q <= 1'b1;
      else if (xfer_done) valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (cfg_we) begin
      hi_cnt <= cfg_wdata[CFG_HI_LSB +: CNT_W];
      lo_cnt <= cfg_wdata[CFG_LO_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          err_q <= 1'b0;
    else if (nack_seen)                  err_q <= 1'b1;
    else if (err_clr_we && err_clr_bit)  err_q <= 1'b0;
  end

  assign err_flag  = err_q;
  assign cmd_rdata = {{PAD_W{1'b0}}, valid_q, data_q, reg_q, 1'b0, addr_q};
endmodule

// File: rtl/i2cbw_seq.sv
module i2cbw_seq
  import i2cbw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = CNT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [FRAME_W-1:0] launch_frame,
  input  logic [CNT_W-1:0]   hi_cnt,
  input  logic [CNT_W-1:0]   lo_cnt,
  input  logic               phase_done,
  input  logic               sda_in,
  output logic               tmr_load,
  output logic [LEN_W-1:0]   tmr_val,
  output logic               busy,
  output logic               xfer_done,
  output logic               nack_seen,
  output logic               in_bit_hi,
  output logic               scl_drive_low,
  output logic               sda_drive_low
);
  localparam int BIT_W  = $clog2(BYTE_W + 1);
  localparam int BYTE_IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  seq_st_t             st_q;
  logic [BIT_W-1:0]    bit_q;
  logic [BYTE_IW-1:0]  byte_q;
  logic [FRAME_W-1:0]  sh_q;
  logic                sda_q;

  logic ack_slot, last_byte, slot_end, want_low;
  logic [LEN_W-1:0] hi_len_m1, lo_len_m1;

  assign hi_len_m1 = LEN_W'(phase_cycles(32'(hi_cnt), HI_OFS) - 1);
  assign lo_len_m1 = LEN_W'(phase_cycles(32'(lo_cnt), LO_OFS) - 1);

  assign ack_slot  = (bit_q == BIT_W'(BYTE_W));
  assign last_byte = (byte_q == BYTE_IW'(NBYTES - 1));
  assign slot_end  = (st_q == S_BIT_HI) && phase_done;
  assign nack_seen = slot_end && ack_slot && sda_in;
  assign xfer_done = (st_q == S_STOP_HI) && phase_done;
  assign busy      = (st_q != S_IDLE);
  assign in_bit_hi = (st_q == S_BIT_HI);

  always_comb begin
    tmr_load = ((st_q == S_IDLE) && launch) ||
               ((st_q != S_IDLE) && (st_q != S_STOP_HI) && phase_done);
    if (st_q == S_IDLE || st_q == S_BIT_LO || st_q == S_STOP_LO) tmr_val = hi_len_m1;
    else                                                         tmr_val = lo_len_m1;
  end

  always_comb begin
    unique case (st_q)
      S_START, S_STOP_LO, S_STOP_HI: want_low = 1'b1;
      S_BIT_LO, S_BIT_HI:            want_low = !ack_slot && !sh_q[FRAME_W-1];
      default:                       want_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      bit_q  <= '0;
      byte_q <= '0;
      sh_q   <= '0;
      sda_q  <= 1'b0;
    end else begin
      sda_q <= want_low;
      unique case (st_q)
        S_IDLE: if (launch) begin
          st_q <= S_START;
          sh_q <= launch_frame;
        end
        S_START: if (phase_done) begin
          st_q   <= S_BIT_LO;
          bit_q  <= '0;
          byte_q <= '0;
        end
        S_BIT_LO: if (phase_done) st_q <= S_BIT_HI;
        S_BIT_HI: if (phase_done) begin
          if (!ack_slot) begin
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
            st_q  <= S_BIT_LO;
          end else if (sda_in || last_byte) begin
            st_q <= S_STOP_LO;
          end else begin
            bit_q  <= '0;
            byte_q <= byte_q + 1'b1;
            st_q   <= S_BIT_LO;
          end
        end
        S_STOP_LO: if (phase_done) st_q <= S_STOP_HI;
        S_STOP_HI: if (phase_done) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign scl_drive_low = (st_q == S_BIT_LO) || (st_q == S_STOP_LO);
  assign sda_drive_low = sda_q;
endmodule

// File: rtl/i2c_bypass_writer.sv
module i2c_bypass_writer
  import i2cbw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] cmd_rdata,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              err_clr_we,
  input  logic              err_clr_bit,
  output logic              err_flag,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              sda_in
);
  localparam int LEN_W = CNT_W + 1;

  logic               launch, busy, xfer_done, nack_seen, in_bit_hi;
  logic               phase_done, tmr_load;
  logic [LEN_W-1:0]   tmr_val;
  logic [FRAME_W-1:0] launch_frame;
  logic [CNT_W-1:0]   hi_cnt, lo_cnt;

  i2cbw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .err_clr_we(err_clr_we), .err_clr_bit(err_clr_bit),
    .busy(busy), .xfer_done(xfer_done), .nack_seen(nack_seen),
    .launch(launch), .launch_frame(launch_frame),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .cmd_rdata(cmd_rdata), .err_flag(err_flag)
  );

  i2cbw_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_frame(launch_frame),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .phase_done(phase_done), .sda_in(sda_in),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .busy(busy), .xfer_done(xfer_done), .nack_seen(nack_seen),
    .in_bit_hi(in_bit_hi),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  i2cbw_phase_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .done(phase_done)
  );
endmodule

// File: rtl/i2cbw_chk.sv
module i2cbw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        busy,
  input logic        xfer_done,
  input logic        nack_seen,
  input logic        in_bit_hi,
  input logic        cmd_we,
  input logic [31:0] cmd_rdata,
  input logic        err_flag,
  input logic        scl_drive_low,
  input logic        sda_drive_low
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= '0;
    else if (scl_drive_low) low_run <= low_run + 1'b1;
    else                    low_run <= '0;
  end

  // R2
  launch_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && cmd_rdata[24]));

  // R2
  valid_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[24] == busy);

  // R2
  done_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !cmd_rdata[24]);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy) |=> $stable(cmd_rdata[23:0]));

  // R6
  sda_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_bit_hi |-> $stable(sda_drive_low));

  // R7
  nack_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> err_flag);

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!scl_drive_low && !sda_drive_low));

  // R5
  min_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> (low_run >= 16'd7));
endmodule

bind i2c_bypass_writer i2cbw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
  .xfer_done(xfer_done), .nack_seen(nack_seen), .in_bit_hi(in_bit_hi),
  .cmd_we(cmd_we), .cmd_rdata(cmd_rdata), .err_flag(err_flag),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_bypass_writer_tb.sv
module i2c_bypass_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, cfg_we = 1'b0, err_clr_we = 1'b0, err_clr_bit = 1'b0;
  logic [31:0] cmd_wdata = '0, cfg_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        err_flag, scl_drive_low, sda_drive_low, sda_in;
  logic        slave_pull = 1'b0;

  int checks = 0, failures = 0;
  int exp_hi = 5, exp_lo = 7;
  int starts = 0;
  bit tx_phase_bad = 0;
  bit finished = 0;

  typedef struct {
    logic [6:0] addr;
    logic [7:0] regv;
    logic [7:0] data;
    int         nack_at;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  assign sda_in = !(sda_drive_low || slave_pull);

  i2c_bypass_writer dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .err_clr_we(err_clr_we), .err_clr_bit(err_clr_bit), .err_flag(err_flag),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_in)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // Bus monitor and receiving device model.
  bit       prev_scl = 1, prev_sda = 1, in_tx = 0, seen_rise = 0;
  int       bitcnt = 0, nbytes = 0, lo_run = 0, hi_run = 0, cur_nack = 3;
  logic [7:0] shb;
  logic [7:0] rxb [3];

  always @(negedge clk) begin
    bit scl, sda;
    if (rst_n) begin
      scl = !scl_drive_low;
      sda = sda_in;
      if (prev_scl && scl && prev_sda && !sda) begin
        in_tx = 1; bitcnt = 0; nbytes = 0; seen_rise = 0; starts++;
        cur_nack = (sb_q.size() > 0) ? sb_q[0].nack_at : 3;
      end else if (prev_scl && scl && !prev_sda && sda && in_tx) begin
        exp_t e;
        int   exp_n;
        in_tx = 0;
        if (sb_q.size() == 0) begin
          check(0, "R2", "unexpected transaction", 32'(nbytes), 0);
        end else begin
          e = sb_q.pop_front();
          exp_n = (e.nack_at > 2) ? 3 : e.nack_at + 1;
          check(nbytes == exp_n, "R7", "bytes before STOP", 32'(nbytes), 32'(exp_n));
          if (nbytes >= 1) check(rxb[0] == {e.addr, 1'b0}, "R6", "address byte", 32'(rxb[0]), 32'({e.addr, 1'b0}));
          if (nbytes >= 2) check(rxb[1] == e.regv, "R6", "register byte", 32'(rxb[1]), 32'(e.regv));
          if (nbytes >= 3) check(rxb[2] == e.data, "R6", "data byte", 32'(rxb[2]), 32'(e.data));
        end
      end
      if (!prev_scl && scl) begin
        if (in_tx && lo_run != exp_lo) tx_phase_bad = 1;
        hi_run = 1; seen_rise = 1;
        if (in_tx) begin
          if (bitcnt < 8) begin
            shb = {shb[6:0], sda};
            bitcnt++;
          end else begin
            if (nbytes < 3) rxb[nbytes] = shb;
            nbytes++;
            bitcnt = 0;
          end
        end
      end else if (prev_scl && !scl) begin
        if (in_tx && seen_rise && hi_run != exp_hi) tx_phase_bad = 1;
        lo_run = 1;
        slave_pull = in_tx && (bitcnt == 8) && (nbytes != cur_nack);
      end else if (scl) hi_run++;
      else lo_run++;
      prev_scl = scl;
      prev_sda = sda;
    end
  end

  task automatic write_cfg(int hi, int lo, logic [15:0] upper);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = {upper, 8'(lo), 8'(hi)};
    @(negedge clk);
    cfg_we = 0;
    exp_hi = hi + 5; exp_lo = lo + 7;
  endtask

  task automatic write_cmd(logic [31:0] w);
    @(negedge clk);
    cmd_we = 1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (cmd_rdata[24] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(!cmd_rdata[24], req, "start flag cleared", cmd_rdata, 0);
  endtask

  task automatic send(logic [6:0] a, logic [7:0] r, logic [7:0] d, int nack_at, string req);
    exp_t e;
    int   s0 = starts;
    e.addr = a; e.regv = r; e.data = d; e.nack_at = nack_at;
    sb_q.push_back(e);
    tx_phase_bad = 0;
    write_cmd({7'h0, 1'b1, d, r, 1'b0, a});
    check(cmd_rdata[24], "R2", "start flag set while busy", cmd_rdata, 32'h0100_0000);
    wait_idle("R2");
    repeat (3) @(negedge clk);
    check(starts == s0 + 1, "R2", "one START per command", 32'(starts - s0), 1);
    check(!tx_phase_bad, req, "SCL phase lengths", 32'(tx_phase_bad), 0);
    check(err_flag == (nack_at <= 2), "R7", "error flag", 32'(err_flag), 32'(nack_at <= 2));
    check(cmd_rdata == {8'h01 & 8'h00, d, r, 1'b0, a}, "R1", "readback fields", cmd_rdata, {8'h0, d, r, 1'b0, a});
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!scl_drive_low && !sda_drive_low, "R10", "lines released after reset", {scl_drive_low, sda_drive_low}, 0);
    check(cmd_rdata == 0, "R10", "command readback after reset", cmd_rdata, 0);
    check(!err_flag, "R10", "error flag after reset", 32'(err_flag), 0);

    write_cfg(10, 14, 16'h0000);
    send(7'h12, 8'h34, 8'hA5, 3, "R4");
    send(7'h7F, 8'h00, 8'hFF, 3, "R4");
    write_cfg(3, 2, 16'hCDAB);
    send(7'h55, 8'h81, 8'h3C, 3, "R3");
    write_cfg(0, 0, 16'hFFFF);
    send(7'h01, 8'hFE, 8'h01, 3, "R5");
    write_cfg(6, 9, 16'h0000);

    send(7'h2A, 8'h10, 8'h20, 0, "R4");
    @(negedge clk); err_clr_we = 1; err_clr_bit = 0;
    @(negedge clk); err_clr_we = 0;
    @(negedge clk);
    check(err_flag, "R8", "write of 0 keeps error", 32'(err_flag), 1);
    @(negedge clk); err_clr_we = 1; err_clr_bit = 1;
    @(negedge clk); err_clr_we = 0;
    @(negedge clk);
    check(!err_flag, "R8", "write of 1 clears error", 32'(err_flag), 0);

    send(7'h33, 8'h44, 8'h55, 2, "R4");
    @(negedge clk); err_clr_we = 1; err_clr_bit = 1;
    @(negedge clk); err_clr_we = 0;
    send(7'h66, 8'h77, 8'h88, 1, "R4");
    @(negedge clk); err_clr_we = 1; err_clr_bit = 1;
    @(negedge clk); err_clr_we = 0;

    // R2: command written with the start flag clear is stored only.
    s0 = starts;
    write_cmd({7'h0, 1'b0, 8'h9C, 8'h5A, 1'b1, 7'h3B});
    repeat (200) @(negedge clk);
    check(starts == s0, "R2", "no transaction without start flag", 32'(starts - s0), 0);
    check(cmd_rdata == {8'h0, 8'h9C, 8'h5A, 1'b0, 7'h3B}, "R1", "stored fields, bit 7 zero", cmd_rdata, {8'h0, 8'h9C, 8'h5A, 1'b0, 7'h3B});

    // R9: write during a transaction is ignored.
    begin
      exp_t e;
      e.addr = 7'h0C; e.regv = 8'hC3; e.data = 8'h5E; e.nack_at = 3;
      sb_q.push_back(e);
      s0 = starts;
      write_cmd({7'h0, 1'b1, 8'h5E, 8'hC3, 1'b0, 7'h0C});
      repeat (60) @(negedge clk);
      write_cmd({7'h0, 1'b1, 8'h11, 8'h22, 1'b0, 7'h33});
      check(cmd_rdata[23:0] == {8'h5E, 8'hC3, 1'b0, 7'h0C}, "R9", "fields kept while busy", cmd_rdata, {8'h5E, 8'hC3, 1'b0, 7'h0C});
      wait_idle("R9");
      repeat (300) @(negedge clk);
      check(starts == s0 + 1, "R9", "ignored write started nothing", 32'(starts - s0), 1);
    end

    check(sb_q.size() == 0, "R2", "scoreboard drained", 32'(sb_q.size()), 0);
    check(!scl_drive_low && !sda_drive_low, "R10", "lines released when idle", {scl_drive_low, sda_drive_low}, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule